// File: doc/BRIEF.md
# Selectable-Resolution PWM Channel with Shadow Reload

This block is a single PWM channel. It watches a free-running 16-bit timebase that is shared with other channels, and a pulse tells it each time the timebase advances. The PWM period is 9, 10 or 11 bits long, chosen by a two-bit length code. The output rises when the low N bits of the timebase equal the active compare value. It falls when that N-bit field wraps to zero.

At every wrap, a shadow reload value is copied into the active compare register. Software therefore changes the duty cycle by writing the shadow, and the new value takes effect at the start of the next period with no partial pulse.

A byte-wide host port has four addresses. The shadow and the active compare register share the two data addresses, and a bank bit chooses which one is reached. Writing the low data byte disables the comparator and writing the high data byte enables it, so a low-then-high write sequence arms the channel.

Top module: `respwm_channel`

## Requirements
- R1: After reset, all four host addresses read 0x00 and `pwm_out` is low.
- R2: Address 2 bits [2:1] hold the length code: 01 selects N=9, 10 selects N=10 and 11 selects N=11. On a timebase advance whose new value has its low N bits all zero (a wrap), bit 7 of address 2 (the overflow flag) is set. On the next edge `pwm_out` goes low, unless R4's zero case applies. Wraps therefore recur every 2^N advances.
- R3: On an advance where the low N bits of the timebase equal the low N bits of the active compare value, and the comparator is enabled and it is not a wrap, `pwm_out` goes high on that edge. Compare bits at N and above are ignored.
- R4: A wrap overrides a match in the same cycle. At a wrap, the output is driven high only when the comparator is enabled and the low N bits of the value being reloaded are zero; otherwise it is driven low. A compare of zero therefore gives a full-period high level, starting from the wrap that loads it.
- R5: At every wrap, the shadow register is copied into the active compare register. This reload takes priority over a host write to the active register in the same cycle.
- R6: Address 2 bit 0 is the bank bit. When it is 1, addresses 0 and 1 read and write the shadow register; when it is 0, they reach the active register. Address 0 holds bits [7:0] of the right-justified value, and address 1 bits [2:0] hold bits [10:8], with its upper bits reading zero.
- R7: Any write to address 0 clears the comparator enable, and any write to address 1 sets it. The enable is address 3 bit 0, and it can also be written there directly.
- R8: While the comparator enable is 0, `pwm_out` is low from the next edge on, and no match occurs.
- R9: Address 3 bit 1 is the match-flag enable. When it is set, every low-to-high transition of `pwm_out` sets the match flag, which is address 3 bit 7.
- R10: Both flags stay set until the host writes 0 to their bit position; writing 1 there leaves them unchanged. A set event in the same cycle as a clearing write leaves the flag set.
- R11: With length code 00, no match and no wrap occur, and `pwm_out` is held low.
- R12: With steady settings and an advance on every clock, `pwm_out` is high for 2^N minus the compare value (low N bits) clocks out of every 2^N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_cnt | input | 16 | Shared timebase value |
| tb_step | input | 1 | Timebase took a new value this cycle |
| wr_en | input | 1 | Host byte write strobe |
| addr | input | 2 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (combinational) |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong reload or a wrong compare register shows up as a shifted rising edge within one period. The bench measures this as a high-time count that differs from 2^N minus the compare value. A lost enable or a stuck length code changes the output on the very next clock edge, because the output is checked on every cycle against an independent model. A flag error shows at the next host read of addresses 2 and 3.

// File: rtl/respwm_pkg.sv
package respwm_pkg;

    typedef enum logic [1:0] {
        A_LO   = 2'd0,
        A_HI   = 2'd1,
        A_CTRL = 2'd2,
        A_MODE = 2'd3
    } reg_addr_e;

    // number of period bits for a length code, 0 when idle
    function automatic int len_bits(input logic [1:0] sel);
        return (sel == 2'b00) ? 0 : 8 + int'(sel);
    endfunction

endpackage

// File: rtl/respwm_event_det.sv
module respwm_event_det
    import respwm_pkg::*;
#(
    parameter int MAX_N = 11
) (
    input  logic [MAX_N-1:0] tb_low,
    input  logic             tb_step,
    input  logic [1:0]       len_sel,
    input  logic             cmp_en,
    input  logic [MAX_N-1:0] cmp_val,
    input  logic [MAX_N-1:0] arl_val,
    output logic             wrap,
    output logic             hit,
    output logic             zhit
);
    logic [MAX_N-1:0] mask;
    logic [MAX_N-1:0] low;
    logic             active;

    for (genvar i = 0; i < MAX_N; i++) begin : g_mask
        assign mask[i] = (i < len_bits(len_sel));
    end

    assign low    = tb_low & mask;
    assign active = tb_step && (len_sel != 2'b00);
    assign wrap   = active && (low == '0);
    assign hit    = active && cmp_en && !wrap && (low == (cmp_val & mask));
    assign zhit   = wrap && cmp_en && ((arl_val & mask) == '0);
endmodule

// File: rtl/respwm_regbank.sv
module respwm_regbank
    import respwm_pkg::*;
#(
    parameter int MAX_N  = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wrap,
    input  logic              hit,
    input  logic              zhit,
    output logic [MAX_N-1:0]  cmp_val,
    output logic [MAX_N-1:0]  arl_val,
    output logic              cmp_en,
    output logic              mat_en,
    output logic              bank,
    output logic [1:0]        len_sel,
    output logic              ovf_flag,
    output logic              mat_flag,
    output logic              pwm
);
    localparam int HI_W = MAX_N - DATA_W;

    typedef struct packed {
        logic [MAX_N-1:0] cmp;
        logic [MAX_N-1:0] arl;
        logic             en;
        logic             mat_en;
        logic             bank;
        logic [1:0]       len;
        logic             ovf;
        logic             mflag;
        logic             out;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            unique case (reg_addr_e'(addr))
                A_LO: begin
                    if (s_q.bank) s_d.arl[DATA_W-1:0] = wdata;
                    else          s_d.cmp[DATA_W-1:0] = wdata;
                    s_d.en = 1'b0;
                end
                A_HI: begin
                    if (s_q.bank) s_d.arl[MAX_N-1:DATA_W] = wdata[HI_W-1:0];
                    else          s_d.cmp[MAX_N-1:DATA_W] = wdata[HI_W-1:0];
                    s_d.en = 1'b1;
                end
                A_CTRL: begin
                    s_d.bank = wdata[0];
                    s_d.len  = wdata[2:1];
                    if (!wdata[DATA_W-1]) s_d.ovf = 1'b0;
                end
                A_MODE: begin
                    s_d.en     = wdata[0];
                    s_d.mat_en = wdata[1];
                    if (!wdata[DATA_W-1]) s_d.mflag = 1'b0;
                end
                default: ;
            endcase
        end

        if (wrap) begin
            s_d.cmp = s_q.arl;
            s_d.ovf = 1'b1;
        end

        if (s_q.len == 2'b00 || !s_q.en) s_d.out = 1'b0;
        else if (wrap)                   s_d.out = zhit;
        else if (hit)                    s_d.out = 1'b1;

        if (s_d.out && !s_q.out && s_q.mat_en) s_d.mflag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmp_val  = s_q.cmp;
    assign arl_val  = s_q.arl;
    assign cmp_en   = s_q.en;
    assign mat_en   = s_q.mat_en;
    assign bank     = s_q.bank;
    assign len_sel  = s_q.len;
    assign ovf_flag = s_q.ovf;
    assign mat_flag = s_q.mflag;
    assign pwm      = s_q.out;
endmodule

// File: rtl/respwm_channel.sv
module respwm_channel
    import respwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MAX_N  = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  tb_cnt,
    input  logic              tb_step,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out
);
    localparam int HI_W = MAX_N - DATA_W;
    localparam int PAD  = DATA_W - HI_W;

    logic [MAX_N-1:0] cmp_w, arl_w, sel_w;
    logic             en_w, mat_en_w, bank_w, ovf_w, mflag_w;
    logic [1:0]       len_w;
    logic             wrap_w, hit_w, zhit_w;
    logic             unused_hi;

    assign unused_hi = ^tb_cnt[CNT_W-1:MAX_N];

    respwm_event_det #(.MAX_N(MAX_N)) det_i (
        .tb_low  (tb_cnt[MAX_N-1:0]),
        .tb_step (tb_step),
        .len_sel (len_w),
        .cmp_en  (en_w),
        .cmp_val (cmp_w),
        .arl_val (arl_w),
        .wrap    (wrap_w),
        .hit     (hit_w),
        .zhit    (zhit_w)
    );

    respwm_regbank #(.MAX_N(MAX_N), .DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .wrap     (wrap_w),
        .hit      (hit_w),
        .zhit     (zhit_w),
        .cmp_val  (cmp_w),
        .arl_val  (arl_w),
        .cmp_en   (en_w),
        .mat_en   (mat_en_w),
        .bank     (bank_w),
        .len_sel  (len_w),
        .ovf_flag (ovf_w),
        .mat_flag (mflag_w),
        .pwm      (pwm_out)
    );

    assign sel_w = bank_w ? arl_w : cmp_w;

    always_comb begin
        unique case (reg_addr_e'(addr))
            A_LO:    rdata = sel_w[DATA_W-1:0];
            A_HI:    rdata = {{PAD{1'b0}}, sel_w[MAX_N-1:DATA_W]};
            A_CTRL:  rdata = {ovf_w, {(DATA_W-4){1'b0}}, len_w, bank_w};
            A_MODE:  rdata = {mflag_w, {(DATA_W-3){1'b0}}, mat_en_w, en_w};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/respwm_channel_chk.sv
module respwm_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwm_out,
    input logic       en,
    input logic [1:0] len,
    input logic       mat_en,
    input logic       ovf,
    input logic       mflag,
    input logic       wrap,
    input logic       hit,
    input logic       zhit
);
    // R8
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_out);

    // R11
    idle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len == 2'b00) |=> !pwm_out);

    // R2
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf);

    // R4
    wrap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !zhit) |=> !pwm_out);

    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> $past(hit || zhit));

    // R9
    match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwm_out) && $past(mat_en)) |-> mflag);
endmodule

bind respwm_channel respwm_channel_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_out (pwm_out),
    .en      (en_w),
    .len     (len_w),
    .mat_en  (mat_en_w),
    .ovf     (ovf_w),
    .mflag   (mflag_w),
    .wrap    (wrap_w),
    .hit     (hit_w),
    .zhit    (zhit_w)
);

// File: tb/respwm_channel_tb.sv
module respwm_channel_tb_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tb_cnt = '0;
    logic        tb_step = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;

    logic [10:0] m_cmp, m_arl;
    logic        m_en, m_mat, m_bank, m_ovf, m_mflag, m_out;
    logic [1:0]  m_len;
    logic [15:0] tbc = '0;

    always #(CLK_NS/2) clk = ~clk;

    respwm_channel dut_i (
        .clk(clk), .rst_n(rst_n), .tb_cnt(tb_cnt), .tb_step(tb_step),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [1:0] a);
        logic [10:0] s;
        s = m_bank ? m_arl : m_cmp;
        case (a)
            2'd0:    return s[7:0];
            2'd1:    return {5'b0, s[10:8]};
            2'd2:    return {m_ovf, 4'b0, m_len, m_bank};
            default: return {m_mflag, 5'b0, m_mat, m_en};
        endcase
    endfunction

    // expected state after one clock edge, from the requirements
    task automatic model_edge(input logic st, input logic [15:0] c, input logic w,
                              input logic [1:0] a, input logic [7:0] d);
        int n;
        logic [10:0] mk, low, ncmp, narl;
        logic act, wr_, h, z, nout, nen, nmat, nbank, novf, nmf;
        logic [1:0] nlen;
        n    = (m_len == 2'b00) ? 0 : 8 + int'(m_len);
        mk   = 11'((1 << n) - 1);
        low  = c[10:0] & mk;
        act  = st && (m_len != 2'b00);
        wr_  = act && (low == 11'd0);
        h    = act && m_en && !wr_ && (low == (m_cmp & mk));
        z    = wr_ && m_en && ((m_arl & mk) == 11'd0);
        if (m_len == 2'b00 || !m_en) nout = 1'b0;
        else if (wr_)                nout = z;
        else if (h)                  nout = 1'b1;
        else                         nout = m_out;
        ncmp = m_cmp; narl = m_arl; nen = m_en; nmat = m_mat; nbank = m_bank;
        nlen = m_len; novf = m_ovf; nmf = m_mflag;
        if (w) begin
            case (a)
                2'd0: begin
                    if (m_bank) narl[7:0] = d; else ncmp[7:0] = d;
                    nen = 1'b0;
                end
                2'd1: begin
                    if (m_bank) narl[10:8] = d[2:0]; else ncmp[10:8] = d[2:0];
                    nen = 1'b1;
                end
                2'd2: begin
                    nbank = d[0]; nlen = d[2:1];
                    if (!d[7]) novf = 1'b0;
                end
                default: begin
                    nen = d[0]; nmat = d[1];
                    if (!d[7]) nmf = 1'b0;
                end
            endcase
        end
        if (wr_) begin
            ncmp = m_arl;
            novf = 1'b1;
        end
        if (nout && !m_out && m_mat) nmf = 1'b1;
        m_cmp = ncmp; m_arl = narl; m_en = nen; m_mat = nmat; m_bank = nbank;
        m_len = nlen; m_ovf = novf; m_mflag = nmf; m_out = nout;
    endtask

    task automatic cyc(input string tag, input logic st, input logic w,
                       input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        if (st) tbc = tbc + 16'd1;
        tb_cnt = tbc; tb_step = st; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        model_edge(st, tbc, w, a, d);
        #1;
        chk(tag, int'(pwm_out), int'(m_out));
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cyc("R7", 1'b0, 1'b1, a, d);
    endtask

    task automatic rd(input string tag, input logic [1:0] a);
        @(negedge clk);
        tb_step = 1'b0; wr_en = 1'b0; addr = a;
        #1;
        chk(tag, int'(rdata), int'(m_read(a)));
        @(posedge clk);
        model_edge(1'b0, tbc, 1'b0, a, 8'h00);
    endtask

    task automatic rdx(input string tag, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        tb_step = 1'b0; wr_en = 1'b0; addr = a;
        #1;
        chk(tag, int'(rdata), int'(exp));
        @(posedge clk);
        model_edge(1'b0, tbc, 1'b0, a, 8'h00);
    endtask

    task automatic run(input string tag, input int cycles);
        for (int i = 0; i < cycles; i++) cyc(tag, 1'b1, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic high_time(input string tag, input int per, input int exp);
        int hi = 0;
        run(tag, per);
        for (int i = 0; i < per; i++) begin
            cyc(tag, 1'b1, 1'b0, 2'd0, 8'h00);
            if (pwm_out) hi++;
        end
        chk(tag, hi, exp);
    endtask

    initial begin : watchdog
        #(CLK_NS * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        m_cmp = '0; m_arl = '0; m_en = 0; m_mat = 0; m_bank = 0;
        m_ovf = 0; m_mflag = 0; m_out = 0; m_len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1; chk("R1", int'(pwm_out), 0);
        for (int a = 0; a < 4; a++) rdx("R1", 2'(a), 8'h00);

        // R6 R7 shadow write, enable toggling
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h40);
        rdx("R7", 2'd3, 8'h00);
        wr(2'd1, 8'h00);
        rdx("R7", 2'd3, 8'h01);
        wr(2'd3, 8'h03);
        rdx("R6", 2'd0, 8'h40);
        wr(2'd2, 8'h02);
        rdx("R6", 2'd0, 8'h00);

        // R12 R5 R9 duty with N=9
        high_time("R12", 512, 448);
        rdx("R5", 2'd0, 8'h40);
        rdx("R2", 2'd2, 8'h82);
        rdx("R9", 2'd3, 8'h83);

        // R10 clear by writing zero, writing one keeps nothing else
        wr(2'd2, 8'h02);
        wr(2'd3, 8'h03);
        rdx("R10", 2'd2, 8'h02);
        rdx("R10", 2'd3, 8'h03);

        // R2 wrap position; R10 set beats clear
        tbc = 16'h05FE;
        cyc("R2", 1'b1, 1'b0, 2'd0, 8'h00);
        rdx("R2", 2'd2, 8'h02);
        cyc("R2", 1'b1, 1'b0, 2'd0, 8'h00);
        chk("R2", int'(pwm_out), 0);
        rdx("R2", 2'd2, 8'h82);
        tbc = 16'h07FE;
        cyc("R10", 1'b1, 1'b0, 2'd0, 8'h00);
        cyc("R10", 1'b1, 1'b1, 2'd2, 8'h02);
        rdx("R10", 2'd2, 8'h82);

        // R4 zero compare -> full high after reload
        wr(2'd2, 8'h03); wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h02);
        high_time("R4", 512, 512);

        // R8 disabled comparator
        wr(2'd3, 8'h02);
        high_time("R8", 512, 0);
        rdx("R8", 2'd3, 8'h02);

        // R3 compare bits above N-1 ignored
        wr(2'd2, 8'h03); wr(2'd0, 8'h40); wr(2'd1, 8'h04); wr(2'd2, 8'h02);
        high_time("R3", 512, 448);

        // R2 R12 longer periods
        wr(2'd2, 8'h05); wr(2'd0, 8'h00); wr(2'd1, 8'h01); wr(2'd2, 8'h04);
        high_time("R12", 1024, 768);
        wr(2'd2, 8'h06);
        high_time("R12", 2048, 1792);

        // R11 idle length code
        wr(2'd2, 8'h00);
        high_time("R11", 512, 0);
        rdx("R11", 2'd2, 8'h00);

        // random mix against the model
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 4000; i++) begin
            logic st, w;
            st = ($urandom % 4) != 0;
            w  = ($urandom % 8) == 0;
            cyc("R3", st, w, 2'($urandom), 8'($urandom));
            if (i % 32 == 0) rd("R6", 2'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule